// File: doc/BRIEF.md
# DRAM Power-Up Initialisation and CBR Refresh Sequencer

This block sits beside the access controller of a fast page mode DRAM array and takes care of two things the controller should not have to think about. After reset it keeps the memory untouched for a fixed settling pause. It then runs a train of warm-up refresh cycles on its own, because the bus is assumed to be its own until initialisation ends. When the warm-up is over it raises a ready flag that stays high.

From then on an interval timer asks for one refresh per interval. The interval is sized so that the whole row space is covered within the retention period. Each refresh uses the /CAS-before-/RAS method, so the device's internal row counter picks the row and no address is driven. The block raises a request and holds it until the access controller grants the bus. It then drives /RAS, /CAS and /WE itself for one cycle and pulses a done strobe when the cycle ends.

If the controller holds off the grant across several intervals, the missed refreshes are counted, up to a fixed limit. They are worked off back to back as soon as the grant arrives.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted and directly after it, `ras_n`, `cas_n` and `we_n` are high, `init_done`, `ref_req` and `ref_done` are low, and `strobe_own` is high.
- R2: After reset is released, the first strobe activity (`cas_n` low) comes no sooner than `PAUSE_CYC` clock cycles and no later than `PAUSE_CYC`+2 cycles.
- R3: After the pause, exactly `WARM_N` refresh cycles are issued without any grant. `init_done` then rises and stays high until reset. `ref_req` and `ref_done` stay low while `init_done` is low.
- R4: In every refresh cycle, `cas_n` is low for at least `T_CSR` cycles before `ras_n` falls. `cas_n` stays low for at least `T_CHR` cycles counted from the fall of `ras_n`. `cas_n` is back high at least one cycle before `ras_n` rises.
- R5: `ras_n` stays low for exactly `T_RAS` cycles in each refresh cycle. Between two refresh cycles it stays high for at least `T_RP` cycles.
- R6: `we_n` is high whenever `ras_n` is low.
- R7: The first `ref_req` rises exactly `INTERVAL_CYC` cycles after `init_done` rises. Later requests arise one per `INTERVAL_CYC` cycles.
- R8: After initialisation, `ref_req` stays high as long as `ref_gnt` is low. No strobe moves without a grant, and `strobe_own` is low while no refresh cycle runs.
- R9: Each granted refresh cycle ends with `ref_done` high for exactly one cycle. `ref_req` goes low the cycle after the done pulse of the last outstanding refresh.
- R10: Refreshes whose request was not granted accumulate, one per elapsed interval. When the grant is given they run back to back, one refresh cycle per accumulated request.
- R11: The backlog saturates at `MAX_PEND`. However long the grant is withheld, at most `MAX_PEND` refresh cycles follow it.
- R12: `strobe_own` is high during every refresh cycle after initialisation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Bus grant from the access controller |
| ref_req | output | 1 | Refresh request, held until served |
| ref_done | output | 1 | One-cycle pulse at the end of each granted refresh |
| init_done | output | 1 | High once the pause and warm-up are complete |
| strobe_own | output | 1 | High while this block drives the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high during refresh |

## Verification
A wrong strobe phase or phase counter shows directly on `ras_n` and `cas_n` within one refresh cycle. It appears as a missing /CAS lead, an early /CAS release, or a /RAS low width other than `T_RAS`. A miscounted pause or warm-up shifts the first /CAS fall or changes the number of /RAS pulses before `init_done`. Both are visible before the first request.

A corrupted backlog counter cannot be seen while the grant is held off. It shows only once the grant is given, as a number of back-to-back /RAS pulses and done strobes that differs from the number of intervals that elapsed, or that exceeds `MAX_PEND`.

// File: rtl/drs_pkg.sv
package drs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_CSR,
    PH_RASL,
    PH_PRE
  } cbr_phase_e;

  typedef enum logic [1:0] {
    ST_PAUSE,
    ST_WARM,
    ST_RUN
  } seq_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int floor_div(input int num, input int den);
    return num / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Bits needed for a counter that runs 0 .. n-1.
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/drs_cbr_engine.sv
module drs_cbr_engine
  import drs_pkg::*;
#(
  parameter int T_CSR = 1,
  parameter int T_CHR = 2,
  parameter int T_RAS = 12,
  parameter int T_RP  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle,
  output logic done,
  output logic ras_n,
  output logic cas_n
);

  localparam int LEN_MAX = max2(max2(T_CSR, T_RAS), T_RP);
  localparam int CW      = cnt_w(LEN_MAX + 1);

  cbr_phase_e     phase;
  logic [CW-1:0]  cnt;
  logic           last;

  function automatic int phase_len(input cbr_phase_e ph);
    case (ph)
      PH_CSR:  return T_CSR;
      PH_RASL: return T_RAS;
      PH_PRE:  return T_RP;
      default: return 1;
    endcase
  endfunction

  function automatic cbr_phase_e phase_next(input cbr_phase_e ph);
    case (ph)
      PH_CSR:  return PH_RASL;
      PH_RASL: return PH_PRE;
      default: return PH_IDLE;
    endcase
  endfunction

  assign last = (cnt == CW'(phase_len(phase) - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (phase == PH_IDLE) begin
      if (start) begin
        phase <= PH_CSR;
        cnt   <= '0;
      end
    end else if (last) begin
      phase <= phase_next(phase);
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign idle  = (phase == PH_IDLE);
  assign done  = (phase == PH_PRE) && last;
  assign ras_n = (phase != PH_RASL);
  assign cas_n = !((phase == PH_CSR) ||
                   ((phase == PH_RASL) && (cnt < CW'(T_CHR))));

endmodule

// File: rtl/drs_interval_timer.sv
module drs_interval_timer
  import drs_pkg::*;
#(
  parameter int PERIOD = 3125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);

  localparam int TW = cnt_w(PERIOD);

  logic [TW-1:0] cnt;

  assign tick = en && (cnt == TW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/drs_pending_ctr.sv
module drs_pending_ctr
  import drs_pkg::*;
#(
  parameter int MAX_PEND = 8,
  parameter int PW       = cnt_w(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [PW-1:0] cnt,
  output logic          nonzero
);

  assign nonzero = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   if (cnt != PW'(MAX_PEND)) cnt <= cnt + 1'b1;
        2'b01:   if (cnt != '0) cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import drs_pkg::*;
#(
  parameter int CLK_PS       = 5000,
  parameter int PAUSE_NS     = 200_000,
  parameter int RETENTION_NS = 32_000_000,
  parameter int ROWS         = 2048,
  parameter int WARM_N       = 8,
  parameter int MAX_PEND     = 8,
  parameter int PAUSE_CYC    = ceil_div(PAUSE_NS * 1000, CLK_PS),
  parameter int INTERVAL_CYC = floor_div(floor_div(RETENTION_NS, ROWS) * 1000, CLK_PS),
  parameter int T_CSR        = ceil_div(5_000, CLK_PS),
  parameter int T_CHR        = ceil_div(10_000, CLK_PS),
  parameter int T_RAS        = ceil_div(60_000, CLK_PS),
  parameter int T_RP         = ceil_div(40_000, CLK_PS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  output logic ref_req,
  output logic ref_done,
  output logic init_done,
  output logic strobe_own,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);

  localparam int PCW = cnt_w(PAUSE_CYC);
  localparam int WCW = cnt_w(WARM_N);
  localparam int PW  = cnt_w(MAX_PEND + 1);

  seq_state_e     state;
  logic [PCW-1:0] pause_cnt;
  logic [WCW-1:0] warm_cnt;

  // Named internal events, also watched by the bound checker.
  logic           eng_start;
  logic           eng_idle;
  logic           eng_done;
  logic           tick;
  logic [PW-1:0]  pend_cnt;
  logic           pend_nz;
  logic           pause_over;
  logic           warm_last;

  assign pause_over = (pause_cnt == PCW'(PAUSE_CYC - 1));
  assign warm_last  = eng_done && (warm_cnt == WCW'(WARM_N - 1));

  assign eng_start = eng_idle &&
                     ((state == ST_WARM) ||
                      ((state == ST_RUN) && pend_nz && ref_gnt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_PAUSE;
      pause_cnt <= '0;
      warm_cnt  <= '0;
      init_done <= 1'b0;
    end else begin
      case (state)
        ST_PAUSE: begin
          if (pause_over) state <= ST_WARM;
          else            pause_cnt <= pause_cnt + 1'b1;
        end
        ST_WARM: begin
          if (warm_last) begin
            state     <= ST_RUN;
            init_done <= 1'b1;
          end else if (eng_done) begin
            warm_cnt <= warm_cnt + 1'b1;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  drs_cbr_engine #(
    .T_CSR (T_CSR),
    .T_CHR (T_CHR),
    .T_RAS (T_RAS),
    .T_RP  (T_RP)
  ) i_engine (
    .clk   (clk),
    .rst_n (rst_n),
    .start (eng_start),
    .idle  (eng_idle),
    .done  (eng_done),
    .ras_n (ras_n),
    .cas_n (cas_n)
  );

  drs_interval_timer #(
    .PERIOD (INTERVAL_CYC)
  ) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (init_done),
    .tick  (tick)
  );

  drs_pending_ctr #(
    .MAX_PEND (MAX_PEND),
    .PW       (PW)
  ) i_pending (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (tick),
    .dec     (ref_done),
    .cnt     (pend_cnt),
    .nonzero (pend_nz)
  );

  assign ref_req    = init_done && pend_nz;
  assign ref_done   = init_done && eng_done;
  assign strobe_own = !init_done || !eng_idle;
  assign we_n       = 1'b1;

endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
  parameter int T_RAS    = 12,
  parameter int MAX_PEND = 8,
  parameter int PW       = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          ref_req,
  input logic          ref_gnt,
  input logic          ref_done,
  input logic          init_done,
  input logic          strobe_own,
  input logic          tick,
  input logic [PW-1:0] pend_cnt
);

  logic [15:0] ras_lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)      ras_lo_cnt <= '0;
    else if (!ras_n) ras_lo_cnt <= ras_lo_cnt + 1'b1;
    else             ras_lo_cnt <= '0;
  end

  AST_CAS_BEFORE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));  // R4

  AST_CAS_RISES_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (cas_n && $past(cas_n)));  // R4

  AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (ras_lo_cnt == 16'(T_RAS)));  // R5

  AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);  // R3

  AST_QUIET_DURING_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (!ref_req && !ref_done));  // R3

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt && !strobe_own) |=> ref_req);  // R8

  AST_NO_STROBE_UNOWNED: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !strobe_own) |-> (ras_n && cas_n));  // R8

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |=> !ref_done);  // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_cnt == PW'(MAX_PEND)) && tick && !ref_done) |=> (pend_cnt == PW'(MAX_PEND)));  // R11

endmodule

bind dram_refresh_seq drs_checker #(
  .T_RAS    (T_RAS),
  .MAX_PEND (MAX_PEND),
  .PW       (PW)
) i_drs_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .ref_req    (ref_req),
  .ref_gnt    (ref_gnt),
  .ref_done   (ref_done),
  .init_done  (init_done),
  .strobe_own (strobe_own),
  .tick       (tick),
  .pend_cnt   (pend_cnt)
);

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;

  localparam int PAUSE_CYC    = 300;
  localparam int INTERVAL_CYC = 200;
  localparam int WARM_N       = 8;
  localparam int MAX_PEND     = 8;
  localparam int T_CSR        = 1;
  localparam int T_CHR        = 2;
  localparam int T_RAS        = 12;
  localparam int T_RP         = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_gnt = 1'b0;
  logic ref_req, ref_done, init_done, strobe_own, ras_n, cas_n, we_n;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // 200 MHz clock
  always #2.5 clk = ~clk;

  dram_refresh_seq #(
    .WARM_N       (WARM_N),
    .MAX_PEND     (MAX_PEND),
    .PAUSE_CYC    (PAUSE_CYC),
    .INTERVAL_CYC (INTERVAL_CYC),
    .T_CSR        (T_CSR),
    .T_CHR        (T_CHR),
    .T_RAS        (T_RAS),
    .T_RP         (T_RP)
  ) i_dram_refresh_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_gnt    (ref_gnt),
    .ref_req    (ref_req),
    .ref_done   (ref_done),
    .init_done  (init_done),
    .strobe_own (strobe_own),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Waveform monitor, sampled away from the active edge.
  int  v_r4 = 0, v_r5 = 0, v_r6 = 0, v_r12 = 0, ras_falls = 0;
  int  cas_low_run = 0, ras_low_run = 0, ras_high_run = 0, cas_in_ras = 0;
  bit  prev_ras = 1'b1, prev_cas = 1'b1, seen_cycle = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ras && !ras_n) begin
        ras_falls++;
        if (cas_low_run < T_CSR) v_r4++;
        if (seen_cycle && ras_high_run < T_RP) v_r5++;
        seen_cycle = 1'b1;
        cas_in_ras = 0;
      end
      if (!prev_ras && ras_n) begin
        if (ras_low_run != T_RAS) v_r5++;
        if (cas_in_ras < T_CHR) v_r4++;
        if (!prev_cas) v_r4++;
      end
      if (!ras_n) begin
        if (!we_n) v_r6++;
        if (!cas_n) cas_in_ras++;
        if (init_done && !strobe_own) v_r12++;
      end
      cas_low_run  = cas_n ? 0 : cas_low_run + 1;
      ras_low_run  = ras_n ? 0 : ras_low_run + 1;
      ras_high_run = ras_n ? ras_high_run + 1 : 0;
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic t_reset();
    rst_n   = 1'b0;
    ref_gnt = 1'b0;
    repeat (5) @(negedge clk);
    check(ras_n && cas_n && we_n, "R1 strobes high in reset", {ras_n, cas_n, we_n}, 7);
    check(!init_done && !ref_req && !ref_done, "R1 flags low in reset",
          {init_done, ref_req, ref_done}, 0);
    check(strobe_own, "R1 strobe ownership in reset", strobe_own, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(ras_n && cas_n && !init_done && !ref_req, "R1 state after release",
          {ras_n, cas_n, init_done, ref_req}, 12);
  endtask

  task automatic t_pause();
    int n = 1;
    while (cas_n && ras_n && n < PAUSE_CYC + 50) begin
      @(negedge clk);
      n++;
    end
    check(n >= PAUSE_CYC && n <= PAUSE_CYC + 2, "R2 pause length", n, PAUSE_CYC + 1);
  endtask

  task automatic t_warmup();
    int  falls = 0;
    int  bad   = 0;
    bit  pr    = ras_n;
    int  guard = 0;
    if (!ras_n) falls = 1;
    while (!init_done && guard < 2000) begin
      @(negedge clk);
      guard++;
      if (pr && !ras_n) falls++;
      pr = ras_n;
      if (!init_done && (ref_req || ref_done)) bad++;
    end
    check(falls == WARM_N, "R3 warm-up cycle count", falls, WARM_N);
    check(bad == 0, "R3 no request or done during init", bad, 0);
  endtask

  task automatic t_first_req();
    int n = 0;
    while (!ref_req && n < INTERVAL_CYC + 50) begin
      @(negedge clk);
      n++;
      if (n == 3) check(!strobe_own && ras_n, "R8 bus released after init",
                        strobe_own, 0);
    end
    check(n == INTERVAL_CYC, "R7 first request delay", n, INTERVAL_CYC);
  endtask

  task automatic drain(output int falls, output int dones);
    bit pr = ras_n;
    int guard = 0;
    falls = 0;
    dones = 0;
    while (ref_req && guard < 1000) begin
      @(negedge clk);
      guard++;
      if (pr && !ras_n) falls++;
      pr = ras_n;
      if (ref_done) dones++;
    end
  endtask

  // Request is high here with no grant; let two more intervals pass.
  task automatic t_hold_and_backlog();
    int drop = 0, moved = 0;
    int falls, dones;
    repeat (2 * INTERVAL_CYC + 20) begin
      @(negedge clk);
      if (!ref_req) drop++;
      if (!ras_n || !cas_n || strobe_own) moved++;
    end
    check(drop == 0, "R8 request held without grant", drop, 0);
    check(moved == 0, "R8 no strobes without grant", moved, 0);
    ref_gnt = 1'b1;
    drain(falls, dones);
    check(falls == 3, "R10 backlog cycles run back to back", falls, 3);
    check(dones == 3, "R9 one done pulse per cycle", dones, 3);
    @(negedge clk);
    check(!ref_req, "R9 request low after backlog", ref_req, 0);
  endtask

  task automatic t_single_and_period();
    int n = 0;
    int falls, dones;
    while (!ref_req) @(negedge clk);
    drain(falls, dones);
    check(falls == 1 && dones == 1, "R9 single granted refresh", falls * 10 + dones, 11);
    while (!ref_req && n < 2 * INTERVAL_CYC) begin
      @(negedge clk);
      n++;
    end
    // n counts from the negedge after the request fell
    check(n + (T_CSR + T_RAS + T_RP + 1) == INTERVAL_CYC, "R7 request period",
          n + T_CSR + T_RAS + T_RP + 1, INTERVAL_CYC);
    drain(falls, dones);
  endtask

  task automatic t_saturate();
    int falls, dones;
    ref_gnt = 1'b0;
    while (!ref_req) @(negedge clk);
    repeat (10 * INTERVAL_CYC + 10) @(negedge clk);
    ref_gnt = 1'b1;
    drain(falls, dones);
    check(falls == MAX_PEND, "R11 backlog saturates", falls, MAX_PEND);
    check(dones == MAX_PEND, "R11 done pulses at saturation", dones, MAX_PEND);
  endtask

  initial begin
    t_reset();
    t_pause();
    t_warmup();
    t_first_req();
    t_hold_and_backlog();
    t_single_and_period();
    t_saturate();
    repeat (5) @(negedge clk);
    check(ras_falls > WARM_N, "R4 waveform observed", ras_falls, WARM_N + 1);
    check(v_r4 == 0, "R4 CAS lead and hold", v_r4, 0);
    check(v_r5 == 0, "R5 RAS width and precharge", v_r5, 0);
    check(v_r6 == 0, "R6 write enable high", v_r6, 0);
    check(v_r12 == 0, "R12 ownership during refresh", v_r12, 0);
    finish_run();
  end

endmodule